// File: doc/BRIEF.md
# Two-Wire Control Register Slave with Auto-Increment

This block lets a host on a two-wire serial bus (I2C-compatible) read and write a bank of 26 byte-wide configuration registers. The bus lines are sampled with the local system clock, and SDA is driven only through an active-low open-drain enable. The 7-bit device address is a parameter, except for one bit, which comes from an external select pin. Tying that pin differently lets two copies of the block share a bus.

A write transfer has three parts: the address byte with R/W = 0, then a subaddress byte that loads an internal pointer, then any number of data bytes. Each data byte is stored at the pointer, and the pointer then increments. A read transfer sends bytes starting at the current pointer, which also increments after each byte. The usual sequence is a subaddress write, a repeated START, and then the read. Four of the registers form a 32-bit frequency word. That word is passed to its consumer only when all four bytes are written in order within one transfer.

Protocol states are `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_SUBADDR`, `ST_SUB_ACK`, `ST_WRITE`, `ST_WRITE_ACK`, `ST_READ`, `ST_READ_ACK` and `ST_IGNORE`. The transitions are as follows.

- A START moves any state to `ST_ADDR`. A STOP moves any state to `ST_IDLE`.
- `ST_ADDR`, after eight bits, goes to `ST_ADDR_ACK` on a match or to `ST_IGNORE` on a mismatch.
- `ST_ADDR_ACK`, at the end of the ninth clock, goes to `ST_SUBADDR` for a write or to `ST_READ` for a read.
- `ST_SUBADDR` goes to `ST_SUB_ACK`, and `ST_SUB_ACK` goes to `ST_WRITE`.
- `ST_WRITE` goes to `ST_WRITE_ACK`, and `ST_WRITE_ACK` goes back to `ST_WRITE`.
- `ST_READ`, after eight bits, goes to `ST_READ_ACK`. `ST_READ_ACK` goes back to `ST_READ` when the master acknowledges, or to `ST_IGNORE` when the master does not.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, every register reads 0x00 except two groups. Subaddresses 4, 5, 6 and 7 hold 0x16, 0x7C, 0xF0 and 0x21, least significant byte at subaddress 4. Subaddress 2 holds 0x10, which is the pedestal-enable flag at bit 4. `freq_word` is 0x21F07C16 and `sda_oe` is 0.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP the slave releases SDA and ignores all bus activity until the next START. `sda_oe` never changes while SCL stays high.
- R3: The device address is `DEV_ADDR` with bit `SEL_POS` replaced by `addr_sel`. The address byte is sent MSB first with R/W in bit 0. On a match the slave drives SDA low for the ninth clock. On a mismatch it never drives SDA and ignores the transfer until the next START.
- R4: In a write, the byte after the address loads the pointer. Each following data byte is acknowledged, stored at the pointer, and the pointer then increments by one.
- R5: In a read, each byte is sent MSB first from the pointer, and the pointer then increments. A master ACK (SDA low on the ninth clock) continues the read. A master NACK makes the slave release SDA until the next START or STOP.
- R6: A data byte written to subaddress 26 or above is acknowledged and discarded. Reading such a subaddress returns 0x00.
- R7: `freq_word` is loaded from subaddresses 4 to 7 only when those four are written in that order within one transfer. The byte at subaddress 4 becomes bits 7:0 and the byte at subaddress 7 becomes bits 31:24.
- R8: Writes to subaddresses 5 to 7 that do not follow a write to subaddress 4 in the same unbroken sequence are stored in the registers but leave `freq_word` unchanged. A START or STOP between the bytes also breaks the sequence.
- R9: A repeated START in the middle of a transfer restarts address decoding and keeps the pointer. A subaddress write followed by a read therefore returns data from that subaddress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Sets device address bit `SEL_POS` |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| cfg_regs | output | 208 | All registers; subaddress k is bits 8k+7:8k |
| freq_word | output | 32 | Committed 32-bit frequency word |

## Verification
The bench builds the block with its default parameters: 26 registers, frequency group at subaddress 4, pedestal flag at bit 4 of subaddress 2, and base address 0x54 with the select pin at bit 1. With `addr_sel` tied high the device answers at 0x56, so 0x54 serves as a real near-miss address that differs only in the selectable bit. An 8-bit pointer with 26 registers puts the last valid subaddress (25), the first invalid one (26) and a far one (0x40) within reach of single transfers and of a burst that crosses the edge. The four-byte group at 4 to 7 sits inside the table region, so ordered bursts, isolated writes and sequences split by STOP can all be driven against it.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUBADDR,
        ST_SUB_ACK,
        ST_WRITE,
        ST_WRITE_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_IGNORE
    } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // The pipelines are reset to the idle-bus level (both lines high).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // START and STOP are both SDA edges that occur while SCL is held high.
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rb_fsm.sv
module i2c_rb_fsm
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h54,
    parameter int         SEL_POS  = 1,
    parameter int         PTR_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             addr_sel,
    input  logic [7:0]       rd_data,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic [PTR_W-1:0] rd_addr
);

    slv_state_e       state, state_nxt;
    logic [7:0]       shreg;
    logic [7:0]       tx;
    logic [3:0]       bit_cnt;
    logic [PTR_W-1:0] ptr;
    logic             rw;
    logic             mack;
    logic [6:0]       my_addr;
    logic             byte_done;

    // The select pin replaces one bit of the fixed device address.
    always_comb begin
        my_addr          = DEV_ADDR;
        my_addr[SEL_POS] = addr_sel;
    end

    // A byte is complete on the SCL fall that follows its eighth rising edge.
    assign byte_done = scl_fall && (bit_cnt == 4'd8);

    always_comb begin
        state_nxt = state;
        if (start_det) begin
            state_nxt = ST_ADDR;
        end else if (stop_det) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nxt = ST_IDLE;
                ST_ADDR:      if (byte_done)
                                  state_nxt = (shreg[7:1] == my_addr) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) state_nxt = rw ? ST_READ : ST_SUBADDR;
                ST_SUBADDR:   if (byte_done) state_nxt = ST_SUB_ACK;
                ST_SUB_ACK:   if (scl_fall) state_nxt = ST_WRITE;
                ST_WRITE:     if (byte_done) state_nxt = ST_WRITE_ACK;
                ST_WRITE_ACK: if (scl_fall) state_nxt = ST_WRITE;
                ST_READ:      if (scl_fall && bit_cnt == 4'd7) state_nxt = ST_READ_ACK;
                ST_READ_ACK:  if (scl_fall) state_nxt = mack ? ST_READ : ST_IGNORE;
                ST_IGNORE:    state_nxt = ST_IGNORE;
                default:      state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            tx      <= '0;
            bit_cnt <= '0;
            ptr     <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
        end else if (start_det) begin
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_SUBADDR, ST_WRITE: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR)    rw  <= shreg[0];
                        if (state == ST_SUBADDR) ptr <= shreg;
                        if (state == ST_WRITE)   ptr <= ptr + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && rw) begin
                        tx      <= rd_data;
                        ptr     <= ptr + 1'b1;
                        bit_cnt <= '0;
                    end
                end
                ST_READ: begin
                    if (scl_fall) begin
                        tx      <= {tx[6:0], 1'b0};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                end
                ST_READ_ACK: begin
                    if (scl_rise) mack <= ~sda_s;
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (mack) begin
                            tx  <= rd_data;
                            ptr <= ptr + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_SUB_ACK, ST_WRITE_ACK: sda_oe = 1'b1;
            ST_READ:                               sda_oe = ~tx[7];
            default:                               sda_oe = 1'b0;
        endcase
    end

    assign wr_en   = (state == ST_WRITE) && byte_done;
    assign wr_addr = ptr;
    assign wr_data = shreg;
    assign rd_addr = ptr;

    p_sda_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !start_det && !stop_det) |-> $stable(sda_oe));

    p_mismatch_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && byte_done && shreg[7:1] != my_addr) |=> !sda_oe);

    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == $past(ptr) + 1'b1));

    p_nack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ_ACK && scl_fall && !mack && !start_det && !stop_det) |=> !sda_oe);

endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
    parameter int          NUM_REGS  = 26,
    parameter int          FREQ_BASE = 4,
    parameter logic [31:0] FREQ_RST  = 32'h21F07C16,
    parameter int          PED_REG   = 2,
    parameter int          PED_BIT   = 4,
    parameter int          PTR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  txn_edge,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [PTR_W-1:0]      rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_flat,
    output logic [31:0]           freq_word
);

    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int FREQ_LAST = FREQ_BASE + 3;

    logic [7:0] regs [NUM_REGS];
    logic       seq_live;
    logic [1:0] seq_pos;
    logic       wr_in_range;
    logic       rd_in_range;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    function automatic logic [7:0] rst_val(input int idx);
        logic [31:0] sh;
        if (idx >= FREQ_BASE && idx <= FREQ_LAST) begin
            sh = FREQ_RST >> (8 * (idx - FREQ_BASE));
            return sh[7:0];
        end else if (idx == PED_REG) begin
            return 8'(1 << PED_BIT);
        end
        return 8'h00;
    endfunction

    assign wr_in_range = (wr_addr < PTR_W'(NUM_REGS));
    assign rd_in_range = (rd_addr < PTR_W'(NUM_REGS));
    assign wr_idx      = wr_in_range ? wr_addr[IDX_W-1:0] : '0;
    assign rd_idx      = rd_in_range ? rd_addr[IDX_W-1:0] : '0;
    assign rd_data     = rd_in_range ? regs[rd_idx] : 8'h00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= rst_val(i);
        end else if (wr_en && wr_in_range) begin
            regs[wr_idx] <= wr_data;
        end
    end

    // The frequency word is committed only after an in-order run over the group.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_live  <= 1'b0;
            seq_pos   <= '0;
            freq_word <= FREQ_RST;
        end else if (txn_edge) begin
            seq_live <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == PTR_W'(FREQ_BASE)) begin
                seq_live <= 1'b1;
                seq_pos  <= 2'd1;
            end else if (seq_live && wr_addr == PTR_W'(FREQ_BASE) + PTR_W'(seq_pos)) begin
                if (seq_pos == 2'd3) begin
                    freq_word <= {wr_data, regs[FREQ_BASE+2], regs[FREQ_BASE+1], regs[FREQ_BASE]};
                    seq_live  <= 1'b0;
                end else begin
                    seq_pos <= seq_pos + 2'd1;
                end
            end else begin
                seq_live <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign cfg_flat[8*g +: 8] = regs[g];
    end

    p_commit_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_word) |-> ($past(wr_en) && $past(wr_addr) == PTR_W'(FREQ_LAST)));

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
    parameter logic [6:0]  DEV_ADDR  = 7'h54,
    parameter int          SEL_POS   = 1,
    parameter int          NUM_REGS  = 26,
    parameter int          FREQ_BASE = 4,
    parameter logic [31:0] FREQ_RST  = 32'h21F07C16,
    parameter int          PED_REG   = 2,
    parameter int          PED_BIT   = 4,
    parameter int          SYNC_STG  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic                  addr_sel,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_regs,
    output logic [31:0]           freq_word
);

    localparam int PTR_W = 8;

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr, rd_addr;
    logic [7:0]       wr_data, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_rb_fsm #(.DEV_ADDR(DEV_ADDR), .SEL_POS(SEL_POS), .PTR_W(PTR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .addr_sel(addr_sel), .rd_data(rd_data),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr)
    );

    i2c_rb_regfile #(
        .NUM_REGS(NUM_REGS), .FREQ_BASE(FREQ_BASE), .FREQ_RST(FREQ_RST),
        .PED_REG(PED_REG), .PED_BIT(PED_BIT), .PTR_W(PTR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .txn_edge(start_det | stop_det),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cfg_flat(cfg_regs),
        .freq_word(freq_word)
    );

endmodule

// File: tb/i2c_regbank_slave_bench.sv
`timescale 1ns/1ps
module i2c_regbank_slave_bench;

    localparam int         Q      = 50;
    localparam logic [6:0] ME     = 7'h56;
    localparam logic [6:0] OTHER  = 7'h54;
    // {subaddress, data written, value expected on read-back}
    localparam logic [23:0] VEC [8] = '{
        24'h005A5A, 24'h03C3C3, 24'h197E7E, 24'h1A9900,
        24'h401200, 24'h020000, 24'h0BFFFF, 24'h188181
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b1;
    logic sda_oe;
    logic [207:0] cfg_regs;
    logic [31:0] freq_word;
    wire sda_bus = sda_m & ~sda_oe;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    i2c_regbank_slave u_i2c_regbank_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .cfg_regs(cfg_regs),
        .freq_word(freq_word)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; b = sda_bus; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic nak);
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(nak);
    endtask

    task automatic recv_byte(input logic nak, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(nak);
    endtask

    // Writes n bytes (byte k in d[8k+:8]); any_nak is 1 if any byte went unacknowledged.
    task automatic wr(input logic [7:0] sub, input int n, input logic [31:0] d, output logic any_nak);
        logic nk;
        any_nak = 1'b0;
        bus_start();
        send_byte({ME, 1'b0}, nk); any_nak |= nk;
        send_byte(sub, nk);        any_nak |= nk;
        for (int k = 0; k < n; k++) begin
            send_byte(d[8*k +: 8], nk); any_nak |= nk;
        end
        bus_stop();
    endtask

    // Subaddress write, repeated START, then n bytes read; last byte NACKed.
    task automatic rd(input logic [7:0] sub, input int n, output logic [31:0] d);
        logic nk;
        logic [7:0] b;
        d = '0;
        bus_start();
        send_byte({ME, 1'b0}, nk);
        send_byte(sub, nk);
        bus_start();
        send_byte({ME, 1'b1}, nk);
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, b);
            d[8*k +: 8] = b;
        end
        #Q;
        check("R5 sda released after master NACK", {31'd0, sda_oe}, 32'd0);
        bus_stop();
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic nk;
        logic [31:0] got;
        #1;
        #(10 * 5);
        rst_n = 1'b1;
        #(10 * 5);

        // R1: reset contents
        for (int i = 0; i < 26; i++) begin
            logic [7:0] e;
            e = 8'h00;
            if (i == 2) e = 8'h10;
            if (i == 4) e = 8'h16;
            if (i == 5) e = 8'h7C;
            if (i == 6) e = 8'hF0;
            if (i == 7) e = 8'h21;
            check($sformatf("R1 reset value of register %0d", i), {24'd0, cfg_regs[8*i +: 8]}, {24'd0, e});
        end
        check("R1 reset freq_word", freq_word, 32'h21F07C16);
        check("R1 reset sda_oe", {31'd0, sda_oe}, 32'd0);

        // R2: bytes clocked without a START are ignored
        send_byte({ME, 1'b0}, nk);
        check("R2 no ack without START", {31'd0, nk}, 32'd1);
        send_byte(8'h00, nk);
        send_byte(8'h77, nk);
        bus_stop();
        check("R2 register 0 untouched without START", {24'd0, cfg_regs[7:0]}, 32'h00);
        check("R2 SDA released after STOP", {31'd0, sda_oe}, 32'd0);

        // R3: address differing only in the pin-selected bit
        bus_start();
        send_byte({OTHER, 1'b0}, nk);
        check("R3 no ack on address mismatch", {31'd0, nk}, 32'd1);
        send_byte(8'h00, nk);
        check("R3 subaddress not acked after mismatch", {31'd0, nk}, 32'd1);
        send_byte(8'hAA, nk);
        bus_stop();
        check("R3 register 0 untouched after mismatch", {24'd0, cfg_regs[7:0]}, 32'h00);

        // R4 R5 R6: table of single-byte write and read-back
        for (int i = 0; i < 8; i++) begin
            logic [7:0] s, dw, ex;
            s = VEC[i][23:16]; dw = VEC[i][15:8]; ex = VEC[i][7:0];
            wr(s, 1, {24'd0, dw}, nk);
            check($sformatf("R4 R6 all bytes acked at sub %h", s), {31'd0, nk}, 32'd0);
            rd(s, 1, got);
            check($sformatf("R5 R6 read-back at sub %h", s), got, {24'd0, ex});
        end

        // R4 R5 R9: burst write then burst read through repeated START
        wr(8'h08, 3, 32'h00BEADDE, nk);
        check("R4 burst write acked", {31'd0, nk}, 32'd0);
        check("R4 burst landed at 8..10", {8'd0, cfg_regs[8*8 +: 24]}, 32'h00BEADDE);
        rd(8'h08, 3, got);
        check("R5 R9 burst read after repeated START", got, 32'h00BEADDE);

        // R6: burst read across the end of the bank
        rd(8'h18, 3, got);
        check("R6 read crosses end of bank", got, 32'h00007E81);

        // R7: ordered group write commits
        wr(8'h04, 4, 32'h44332211, nk);
        check("R7 ordered group commits", freq_word, 32'h44332211);

        // R8: isolated writes held but not committed
        wr(8'h05, 3, 32'h00CCBBAA, nk);
        check("R8 isolated bytes stored", {8'd0, cfg_regs[8*5 +: 24]}, 32'h00CCBBAA);
        check("R8 isolated bytes not committed", freq_word, 32'h44332211);
        wr(8'h07, 1, 32'h000000EE, nk);
        check("R8 lone byte 7 not committed", freq_word, 32'h44332211);

        // R8: sequence split by STOP does not commit
        wr(8'h04, 2, 32'h00006655, nk);
        wr(8'h06, 2, 32'h00008877, nk);
        check("R8 split group stored", cfg_regs[8*4 +: 32], 32'h88776655);
        check("R8 split group not committed", freq_word, 32'h44332211);

        // R7: a second ordered group commits again
        wr(8'h04, 4, 32'h0DC0FFEE, nk);
        check("R7 second ordered commit", freq_word, 32'h0DC0FFEE);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule